// File: doc/BRIEF.md
# Peripheral I/O Recovery Gap Controller

This block keeps a minimum idle gap between consecutive peripheral-bus I/O cycles that the host bus starts. It watches the active-low read and write strobes. When a strobe is released, it loads a recovery count and clears its ready flag. The flag comes back only after that many peripheral clocks have passed. A cycle sequencer that has an I/O cycle waiting asks for a start grant. The grant is given only while the controller is ready and no strobe is being driven, and only then may the sequencer begin the next address-latch pulse.

The gap length is programmable. Any setting below the built-in floor of four clocks is raised to the floor, so the gap can be lengthened but never shortened. The setting is captured when a strobe is released, so changing it later does not affect a count that is already running. When a 16-bit access is carried out as two byte accesses, the sequencer marks the first byte with a flag. No gap is inserted after that byte, so the second byte follows directly.

Top module: `io_recovery_ctrl`

## Requirements
- R1: After the synchronous reset, `recov_done` is 1. The first I/O cycle is granted (`start_ok` = 1) in the same cycle that `io_pending` rises, with no delay.
- R2: A strobe release is the first rising clock edge at which a strobe that was low (active) at the previous edge is seen high. `recov_done` falls after that edge. It rises again exactly N rising edges later, where N is the effective delay. Counted from that edge, `recov_done` therefore reads 1 only after the (N+1)-th edge.
- R3: A `dly_cfg` value of 0 to 4 gives an effective delay N of 4 clocks.
- R4: A `dly_cfg` value above 4 gives N = `dly_cfg`, up to the largest value of 31 for the 5-bit setting.
- R5: `dly_cfg` is sampled only at a strobe release. Changing it while a count is running does not change that gap.
- R6: If `split_first` is 1 at the release edge, no gap is inserted: `recov_done` stays 1 throughout.
- R7: Once `recov_done` is 1, it stays 1 until the next strobe release, however long no cycle is pending. A request that arrives later is granted in the same cycle.
- R8: `start_ok` is 0 while either strobe is low, and 0 while `recov_done` is 0. Otherwise `start_ok` equals `io_pending`.
- R9: Releasing the read strobe and releasing the write strobe each start the same gap.
- R10: The running count goes down by exactly one on each clock and never goes below zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral bus clock |
| rst | input | 1 | Synchronous reset, active high |
| io_pending | input | 1 | An I/O cycle from the host bus is waiting to start |
| split_first | input | 1 | The current strobe is the first byte of a split 16-bit access |
| rd_strobe_n | input | 1 | I/O read strobe, active low |
| wr_strobe_n | input | 1 | I/O write strobe, active low |
| dly_cfg | input | 5 | Programmed recovery delay in clocks (floor of 4) |
| recov_done | output | 1 | Registered flag: the recovery gap has expired |
| start_ok | output | 1 | Grant: the pending cycle may begin its address-latch pulse |

## Verification
Each gap is measured by counting rising edges from the point where the bench releases a strobe, one time unit after an edge. `recov_done` must read 0 after the first edge and must first read 1 after edge N+1: one edge for detection and N edges for counting. The bench samples one time unit after every edge and compares the number of edges it counted with N, which it works out from the programmed value and the floor of four. `start_ok` is combinational on `io_pending` and on the strobes, so the bench checks it one time unit after it changes those inputs, with no clock edge in between. For the split case, the bench checks that `recov_done` is still 1 after the edge that sees the release.

// File: rtl/iorc_pkg.sv
package iorc_pkg;

  // Recovery state of the gap counter
  typedef enum logic {
    RC_READY = 1'b0,
    RC_HOLD  = 1'b1
  } rc_state_t;

  // Event produced when an I/O strobe is released
  typedef struct packed {
    logic rel;    // a strobe was released at this edge
    logic split;  // the released strobe was the first byte of a split access
  } rc_evt_t;

endpackage

// File: rtl/iorc_strobe_edge.sv
module iorc_strobe_edge
  import iorc_pkg::*;
#(
  parameter int N_STRB = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_STRB-1:0] strb_n,
  input  logic              split_first,
  output logic              busy,
  output rc_evt_t           evt
);

  logic [N_STRB-1:0] act_vec;
  logic              act_q;

  // Turn the active-low strobes into active-high flags
  genvar gi;
  generate
    for (gi = 0; gi < N_STRB; gi++) begin : g_act
      assign act_vec[gi] = ~strb_n[gi];
    end
  endgenerate

  assign busy = |act_vec;

  // Remember whether any strobe was active at the previous edge
  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= busy;
  end

  // A release is an active strobe at the previous edge that is now idle
  always_comb begin
    evt.rel   = act_q & ~busy;
    evt.split = act_q & ~busy & split_first;
  end

endmodule

// File: rtl/iorc_delay_clamp.sv
module iorc_delay_clamp #(
  parameter int DLY_W   = 5,
  parameter int DEF_DLY = 4
) (
  input  logic [DLY_W-1:0] cfg,
  output logic [DLY_W-1:0] eff
);

  localparam logic [DLY_W-1:0] FLOOR = DLY_W'(DEF_DLY);

  // Raise any setting below the floor; with no floor, pass the setting through
  generate
    if (DEF_DLY > 0) begin : g_floor
      assign eff = (cfg < FLOOR) ? FLOOR : cfg;
    end else begin : g_pass
      assign eff = cfg;
    end
  endgenerate

endmodule

// File: rtl/iorc_gap_counter.sv
module iorc_gap_counter
  import iorc_pkg::*;
#(
  parameter int DLY_W   = 5,
  parameter int DEF_DLY = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  rc_evt_t          evt,
  input  logic [DLY_W-1:0] eff,
  output logic [DLY_W-1:0] cnt,
  output logic             done
);

  localparam logic [DLY_W-1:0] ONE   = DLY_W'(1);
  localparam logic [DLY_W-1:0] FLOOR = DLY_W'(DEF_DLY);

  rc_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RC_READY;
      cnt  <= '0;
      done <= 1'b1;
    end else if (evt.rel) begin
      if (evt.split) begin
        // no gap between the two byte halves of a split access
        st   <= RC_READY;
        cnt  <= '0;
        done <= 1'b1;
      end else begin
        // capture the setting once, when the strobe is released
        st   <= RC_HOLD;
        cnt  <= eff;
        done <= 1'b0;
      end
    end else if (st == RC_HOLD) begin
      cnt <= cnt - ONE;
      if (cnt == ONE) begin
        st   <= RC_READY;
        done <= 1'b1;
      end
    end
  end

  AST_LOAD_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (evt.rel && !evt.split) |=> !done); // R2
  AST_SPLIT_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    (evt.rel && evt.split) |=> done); // R6
  AST_GAP_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (evt.rel && !evt.split) |=> (cnt >= FLOOR)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    ((cnt != '0) && !evt.rel) |=> (cnt == $past(cnt) - ONE)); // R10
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done && !evt.rel) |=> done); // R7
  AST_READY_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    done == (cnt == '0)); // R2

endmodule

// File: rtl/io_recovery_ctrl.sv
module io_recovery_ctrl
  import iorc_pkg::*;
#(
  parameter int DLY_W   = 5,
  parameter int DEF_DLY = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_pending,
  input  logic             split_first,
  input  logic             rd_strobe_n,
  input  logic             wr_strobe_n,
  input  logic [DLY_W-1:0] dly_cfg,
  output logic             recov_done,
  output logic             start_ok
);

  localparam int N_STRB = 2;

  logic             busy;
  rc_evt_t          evt;
  logic [DLY_W-1:0] eff;
  logic [DLY_W-1:0] cnt;

  iorc_strobe_edge #(.N_STRB(N_STRB)) u_edge (
    .clk         (clk),
    .rst         (rst),
    .strb_n      ({wr_strobe_n, rd_strobe_n}),
    .split_first (split_first),
    .busy        (busy),
    .evt         (evt)
  );

  iorc_delay_clamp #(.DLY_W(DLY_W), .DEF_DLY(DEF_DLY)) u_clamp (
    .cfg (dly_cfg),
    .eff (eff)
  );

  iorc_gap_counter #(.DLY_W(DLY_W), .DEF_DLY(DEF_DLY)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .evt  (evt),
    .eff  (eff),
    .cnt  (cnt),
    .done (recov_done)
  );

  // A waiting cycle may start only once the gap is over and the bus is quiet
  assign start_ok = io_pending & recov_done & ~busy;

  AST_GRANT_AFTER_COUNT: assert property (@(posedge clk) disable iff (rst)
    start_ok |-> (cnt == '0)); // R8
  AST_NO_GRANT_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!rd_strobe_n || !wr_strobe_n) |-> !start_ok); // R8

endmodule

// File: tb/io_recovery_ctrl_bench.sv
`timescale 1ns/1ps
module io_recovery_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       io_pending;
  logic       split_first;
  logic       rd_strobe_n;
  logic       wr_strobe_n;
  logic [4:0] dly_cfg;
  logic       recov_done;
  logic       start_ok;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  io_recovery_ctrl u_io_recovery_ctrl (
    .clk(clk), .rst(rst), .io_pending(io_pending), .split_first(split_first),
    .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n), .dly_cfg(dly_cfg),
    .recov_done(recov_done), .start_ok(start_ok)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Drive a strobe low for a few clocks, then release it just after an edge
  task automatic strobe(input bit use_wr, input bit split);
    split_first = split;
    if (use_wr) wr_strobe_n = 1'b0; else rd_strobe_n = 1'b0;
    tick(); tick();
    rd_strobe_n = 1'b1;
    wr_strobe_n = 1'b1;
  endtask

  // Count edges after the release until recov_done reads 1 (expected N+1)
  task automatic count_gap(output int edges);
    edges = 0;
    for (int c = 1; c <= 64; c++) begin
      tick();
      if (c == 1) split_first = 1'b0;
      if (recov_done) begin edges = c; break; end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; io_pending = 1'b0; split_first = 1'b0;
    rd_strobe_n = 1'b1; wr_strobe_n = 1'b1; dly_cfg = 5'd0;
    tick(); tick();
    rst = 1'b0;
    tick();
    chk(recov_done == 1'b1, "R1 ready after reset", recov_done, 1);
    chk(start_ok == 1'b0, "R8 no grant without request", start_ok, 0);
    io_pending = 1'b1;
    #1;
    chk(start_ok == 1'b1, "R1 first cycle not delayed", start_ok, 1);
    io_pending = 1'b0;
  endtask

  task automatic t_gap(input bit use_wr, input logic [4:0] cfg, input int n, input string req);
    int e;
    dly_cfg = cfg;
    strobe(use_wr, 1'b0);
    count_gap(e);
    chk(e == n + 1, req, e, n + 1);
  endtask

  task automatic t_grant_during_gap();
    dly_cfg = 5'd6;
    io_pending = 1'b1;
    rd_strobe_n = 1'b0;
    #1;
    chk(start_ok == 1'b0, "R8 no grant while strobe low", start_ok, 0);
    tick(); tick();
    rd_strobe_n = 1'b1;
    for (int c = 1; c <= 6; c++) begin
      tick();
      if (c == 6) chk(start_ok == 1'b0, "R8 no grant on last gap clock", start_ok, 0);
    end
    tick();
    chk(start_ok == 1'b1, "R2 grant once gap expires", start_ok, 1);
    io_pending = 1'b0;
  endtask

  task automatic t_cfg_change();
    int e;
    dly_cfg = 5'd9;
    strobe(1'b0, 1'b0);
    e = 0;
    for (int c = 1; c <= 64; c++) begin
      tick();
      if (c == 2) dly_cfg = 5'd20;
      if (recov_done) begin e = c; break; end
    end
    chk(e == 10, "R5 setting change mid-gap ignored", e, 10);
  endtask

  task automatic t_split();
    dly_cfg = 5'd12;
    strobe(1'b0, 1'b1);
    tick();
    split_first = 1'b0;
    chk(recov_done == 1'b1, "R6 no gap after split first byte", recov_done, 1);
    io_pending = 1'b1;
    #1;
    chk(start_ok == 1'b1, "R6 second byte granted at once", start_ok, 1);
    io_pending = 1'b0;
  endtask

  task automatic t_sticky();
    int e;
    dly_cfg = 5'd4;
    strobe(1'b1, 1'b0);
    count_gap(e);
    for (int c = 0; c < 20; c++) tick();
    chk(recov_done == 1'b1, "R7 ready held while idle", recov_done, 1);
    io_pending = 1'b1;
    #1;
    chk(start_ok == 1'b1, "R7 late request granted at once", start_ok, 1);
    io_pending = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    t_reset();
    t_gap(1'b0, 5'd0,  4,  "R3 setting 0 gives 4 (read strobe, R9)");
    t_gap(1'b0, 5'd2,  4,  "R3 setting 2 gives 4");
    t_gap(1'b1, 5'd4,  4,  "R3 setting 4 gives 4 (write strobe, R9)");
    t_gap(1'b1, 5'd9,  9,  "R4 setting 9 gives 9 (write strobe, R9)");
    t_gap(1'b0, 5'd5,  5,  "R4 setting 5 gives 5");
    t_gap(1'b0, 5'd31, 31, "R4 largest setting, R10 steps of one");
    t_grant_during_gap();
    t_cfg_change();
    t_split();
    t_sticky();
    report();
  end

endmodule